// File: doc/BRIEF.md
# Dual-Half Segment/Common Dot-Matrix Display Driver Core

This block is the digital core of a 40-channel dot-matrix display driver. It is built as two independent 20-channel halves. Each half has a bidirectional serial shift register, a parallel latch and a per-channel level selector. Serial display data moves into a shift register on falling edges of one clock, and falling edges of the other clock copy the register into the latch. Every channel then gets a 3-bit code that names one of six external bias levels. The code depends on the latched bit and on the alternation input. Each half has a left and a right serial pin, so devices can be chained.

The two display clocks and all other pins are sampled on the core clock `clk`. A small two-state edge machine per display clock (states EDG_LOW and EDG_HIGH; transition "rise" from EDG_LOW to EDG_HIGH, transition "fall" from EDG_HIGH to EDG_LOW) gives a one-cycle pulse on the fall transition only. The mode input routes these pulses. With mode low, both halves use the same clock roles. With mode high, the second half swaps its shift and latch clocks and inverts its alternation input, so it can act as a common driver while the first half acts as a segment driver. Tri-state serial pins appear as separate input, output and output-enable signals.

Top module: `lcd_seg_com_driver`

## Requirements
- R1: After reset, every shift register and latch bit is 0. With `m_i`=0 and `mode_i`=0, channels 1–20 then read code 3 and channels 21–40 read code 5, and all serial outputs read 0.
- R2: With `mode_i`=0, both halves shift on the cycle after `cl2_i` is first seen low following a high, and both load their latch on the cycle after `cl1_i` is first seen low following a high. Between latch loads the channel codes depend only on `m_i`.
- R3: With `dir_i[h]`=1, half h takes the new bit from `right_in_i[h]` into its right end and moves data toward the left. `left_out_o[h]` shows the leftmost register bit, `left_oe_o[h]`=1 and `right_oe_o[h]`=0.
- R4: With `dir_i[h]`=0, half h takes the new bit from `left_in_i[h]` into its left end and moves data toward the right. `right_out_o[h]` shows the rightmost register bit, `right_oe_o[h]`=1 and `left_oe_o[h]`=0.
- R5: A bit written into a half appears on that half's active serial output after 20 shifts, ready for a chained device.
- R6: With `mode_i`=1, half 2 shifts on `cl1_i` falls and latches on `cl2_i` falls, while half 1 keeps the roles of R2.
- R7: With `mode_i`=1, half 2 uses the inverse of `m_i` as its effective alternation value. Half 1 always uses `m_i` as given.
- R8: Channel c (1..40) is at `chan_code_o[3*(c-1)+:3]`, and the code value n names bias level Vn. Channel k of half 1 comes from latch bit k-1, with the latch bit at the left end first. A latched 1 gives V1 when the effective alternation value is 0 and V2 when it is 1. A latched 0 gives V3/V4 in half 1 and V5/V6 in half 2, again for an effective alternation value of 0/1.
- R9: Rising edges and steady levels of either display clock change no register and no latch.
- R10: The two halves operate independently, each with its own direction and serial pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl1_i | input | 1 | Display clock 1 |
| cl2_i | input | 1 | Display clock 2 |
| mode_i | input | 1 | Role swap and alternation inversion for half 2 |
| m_i | input | 1 | Alternation input |
| dir_i | input | 2 | Shift direction per half (bit 0 = half 1) |
| left_in_i | input | 2 | Left serial pin, input side |
| right_in_i | input | 2 | Right serial pin, input side |
| left_out_o | output | 2 | Left serial pin, output side |
| left_oe_o | output | 2 | Left serial pin drive enable |
| right_out_o | output | 2 | Right serial pin, output side |
| right_oe_o | output | 2 | Right serial pin drive enable |
| chan_code_o | output | 120 | 40 channel bias-level codes, 3 bits each |

## Verification
The bench goes after both clocks falling in the same cycle. A latch that takes the value after the shift would show the new data one load too early. It also checks that a rising clock or a held clock level leaves everything unchanged. A design that acts on any level change would shift twice per pulse. Direction flips in mid-stream are covered, where a wrong entry end or a wrong enable would corrupt the chained output. Mode toggles are exercised too, where a half 2 that keeps its clock roles or its alternation polarity would give codes 5/6 swapped or latch at the wrong time.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        LVL_NONE = 3'd0,
        LVL_V1   = 3'd1,
        LVL_V2   = 3'd2,
        LVL_V3   = 3'd3,
        LVL_V4   = 3'd4,
        LVL_V5   = 3'd5,
        LVL_V6   = 3'd6
    } bias_lvl_e;

    typedef enum logic {
        EDG_LOW  = 1'b0,
        EDG_HIGH = 1'b1
    } edge_state_e;

endpackage

// File: rtl/lcd_edge_fsm.sv
module lcd_edge_fsm
    import lcd_drv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o
);

    edge_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDG_LOW:  if (lvl_i)  state_d = EDG_HIGH;  // rise
            EDG_HIGH: if (!lvl_i) state_d = EDG_LOW;   // fall
            default:  state_d = EDG_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        fall_o = 1'b0;
        unique case (state_q)
            EDG_LOW:  fall_o = 1'b0;
            EDG_HIGH: fall_o = !lvl_i;
            default:  fall_o = 1'b0;
        endcase
    end

    AST_FALL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(lvl_i)); // R9

endmodule

// File: rtl/lcd_half.sv
module lcd_half
    import lcd_drv_pkg::*;
#(
    parameter int        NCH     = 20,
    parameter bias_lvl_e NSEL_LO = LVL_V3,
    parameter bias_lvl_e NSEL_HI = LVL_V4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_i,
    input  logic                load_i,
    input  logic                dir_i,
    input  logic                m_eff_i,
    input  logic                left_in_i,
    input  logic                right_in_i,
    output logic                left_out_o,
    output logic                left_oe_o,
    output logic                right_out_o,
    output logic                right_oe_o,
    output logic [NCH*CODE_W-1:0] codes_o
);

    logic [NCH-1:0] sr_q, lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_i) begin
            if (dir_i) sr_q <= {right_in_i, sr_q[NCH-1:1]};
            else       sr_q <= {sr_q[NCH-2:0], left_in_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (load_i) lat_q <= sr_q;
    end

    assign left_out_o  = sr_q[0];
    assign right_out_o = sr_q[NCH-1];
    assign left_oe_o   = dir_i;
    assign right_oe_o  = !dir_i;

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        always_comb begin
            if (lat_q[k]) codes_o[k*CODE_W +: CODE_W] = m_eff_i ? LVL_V2 : LVL_V1;
            else          codes_o[k*CODE_W +: CODE_W] = m_eff_i ? NSEL_HI : NSEL_LO;
        end
    end

    AST_ENTRY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && dir_i) |=> sr_q[NCH-1] == $past(right_in_i)); // R3
    AST_ENTRY_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !dir_i) |=> sr_q[0] == $past(left_in_i)); // R4
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> lat_q == $past(sr_q)); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(lat_q)); // R9
    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(sr_q)); // R9
    AST_SEL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q[0] |-> (codes_o[CODE_W-1:0] == LVL_V1 || codes_o[CODE_W-1:0] == LVL_V2)); // R8

endmodule

// File: rtl/lcd_seg_com_driver.sv
module lcd_seg_com_driver
    import lcd_drv_pkg::*;
#(
    parameter int NCH_HALF = 20,
    localparam int NHALF   = 2,
    localparam int NCH_ALL = NCH_HALF * NHALF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cl1_i,
    input  logic                      cl2_i,
    input  logic                      mode_i,
    input  logic                      m_i,
    input  logic [NHALF-1:0]          dir_i,
    input  logic [NHALF-1:0]          left_in_i,
    input  logic [NHALF-1:0]          right_in_i,
    output logic [NHALF-1:0]          left_out_o,
    output logic [NHALF-1:0]          left_oe_o,
    output logic [NHALF-1:0]          right_out_o,
    output logic [NHALF-1:0]          right_oe_o,
    output logic [NCH_ALL*CODE_W-1:0] chan_code_o
);

    logic fall1, fall2;

    lcd_edge_fsm u_edge1 (.clk(clk), .rst_n(rst_n), .lvl_i(cl1_i), .fall_o(fall1));
    lcd_edge_fsm u_edge2 (.clk(clk), .rst_n(rst_n), .lvl_i(cl2_i), .fall_o(fall2));

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic swap;
        logic shift_p, load_p, m_eff;

        assign swap    = (h == 1) && mode_i;
        assign shift_p = swap ? fall1 : fall2;
        assign load_p  = swap ? fall2 : fall1;
        assign m_eff   = m_i ^ swap;

        lcd_half #(
            .NCH     (NCH_HALF),
            .NSEL_LO ((h == 0) ? LVL_V3 : LVL_V5),
            .NSEL_HI ((h == 0) ? LVL_V4 : LVL_V6)
        ) u_half (
            .clk        (clk),
            .rst_n      (rst_n),
            .shift_i    (shift_p),
            .load_i     (load_p),
            .dir_i      (dir_i[h]),
            .m_eff_i    (m_eff),
            .left_in_i  (left_in_i[h]),
            .right_in_i (right_in_i[h]),
            .left_out_o (left_out_o[h]),
            .left_oe_o  (left_oe_o[h]),
            .right_out_o(right_out_o[h]),
            .right_oe_o (right_oe_o[h]),
            .codes_o    (chan_code_o[h*NCH_HALF*CODE_W +: NCH_HALF*CODE_W])
        );
    end

    AST_H2_ROLE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && fall1 && !dir_i[1]) |=> left_out_o[1] == $past(left_in_i[1])); // R6

endmodule

// File: tb/lcd_seg_com_driver_tb_top.sv
`timescale 1ns/1ps
module lcd_seg_com_driver_tb_top;

    localparam int NCH = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cl1 = 1'b0, cl2 = 1'b0, mode = 1'b0, m = 1'b0;
    logic [1:0] dir = 2'b00, lin = 2'b00, rin = 2'b00;
    logic [1:0] lout, loe, rout, roe;
    logic [NCH*2*3-1:0] codes;

    int n_chk = 0, n_fail = 0;
    logic prev1 = 1'b0, prev2 = 1'b0;
    logic [NCH-1:0] sr_m [2];
    logic [NCH-1:0] lat_m [2];

    always #2 clk = ~clk;

    lcd_seg_com_driver dut_i (
        .clk(clk), .rst_n(rst_n), .cl1_i(cl1), .cl2_i(cl2), .mode_i(mode), .m_i(m),
        .dir_i(dir), .left_in_i(lin), .right_in_i(rin),
        .left_out_o(lout), .left_oe_o(loe), .right_out_o(rout), .right_oe_o(roe),
        .chan_code_o(codes));

    function automatic logic [2:0] exp_code(int h, int k);
        logic me;
        me = m ^ ((h == 1) && mode);
        if (lat_m[h][k]) return me ? 3'd2 : 3'd1;
        if (h == 0)      return me ? 3'd4 : 3'd3;
        return me ? 3'd6 : 3'd5;
    endfunction

    function automatic logic [NCH*2*3-1:0] exp_codes();
        logic [NCH*2*3-1:0] v;
        for (int h = 0; h < 2; h++)
            for (int k = 0; k < NCH; k++)
                v[(h*NCH+k)*3 +: 3] = exp_code(h, k);
        return v;
    endfunction

    task automatic check(string tag, logic [NCH*2*3-1:0] act, logic [NCH*2*3-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int h = 0; h < 2; h++) begin
            logic [3:0] a, e;
            a = {roe[h], rout[h], loe[h], lout[h]};
            e = {!dir[h], sr_m[h][NCH-1], dir[h], sr_m[h][0]};
            check(tag, {116'd0, a}, {116'd0, e});
        end
        check(tag, codes, exp_codes());
    endtask

    // apply clock levels, advance one cycle, update model, check
    task automatic step(logic c1, logic c2, string tag);
        logic f1, f2;
        cl1 = c1; cl2 = c2;
        @(posedge clk); #1;
        f1 = prev1 && !c1; f2 = prev2 && !c2;
        prev1 = c1; prev2 = c2;
        for (int h = 0; h < 2; h++) begin
            logic sw, sh, ld;
            sw = (h == 1) && mode;
            sh = sw ? f1 : f2;
            ld = sw ? f2 : f1;
            if (ld) lat_m[h] = sr_m[h];
            if (sh) sr_m[h] = dir[h] ? {rin[h], sr_m[h][NCH-1:1]} : {sr_m[h][NCH-2:0], lin[h]};
        end
        check_all(tag);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [NCH-1:0] pat;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int h = 0; h < 2; h++) begin sr_m[h] = '0; lat_m[h] = '0; end
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset state");
        rst_n = 1'b1;

        // R2/R4/R5: shift a pattern from the left into both halves
        pat = 20'hA5C3E;
        for (int i = 0; i < NCH; i++) begin
            lin = {pat[i], ~pat[i]};
            step(1'b0, 1'b1, "R9 rising CL2");
            step(1'b0, 1'b0, "R4 shift dir low");
        end
        check("R5 cascade out h1", {119'd0, rout[0]}, {119'd0, ~pat[0]});
        check("R5 cascade out h2", {119'd0, rout[1]}, {119'd0, pat[0]});
        step(1'b0, 1'b0, "R9 held level");
        step(1'b1, 1'b0, "R2 latch not yet");
        step(1'b0, 1'b0, "R2 latch on CL1 fall");
        m = 1'b1;
        step(1'b0, 1'b0, "R8 alternation");

        // R3: right entry, R10 independent direction
        dir = 2'b01; rin = 2'b11;
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, "R3 setup");
            step(1'b0, 1'b0, "R3 R10 shift dir high");
        end

        // R6/R7: mode high, both clocks fall together
        mode = 1'b1;
        step(1'b0, 1'b0, "R7 inverted M half 2");
        lin = 2'b10; rin = 2'b01;
        step(1'b1, 1'b1, "R6 setup");
        step(1'b0, 1'b0, "R6 simultaneous falls");
        step(1'b1, 1'b0, "R6 setup");
        step(1'b0, 1'b0, "R6 half 2 shifts on CL1");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic c1, c2;
            c1 = ($urandom % 3 == 0) ? ~cl1 : cl1;
            c2 = ($urandom % 2 == 0) ? ~cl2 : cl2;
            if ($urandom % 16 == 0) dir = 2'($urandom);
            if ($urandom % 40 == 0) mode = ~mode;
            if ($urandom % 4 == 0) m = ~m;
            lin = 2'($urandom); rin = 2'($urandom);
            step(c1, c2, "R2/R3/R4/R6/R7/R8/R10 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule